// File: doc/BRIEF.md
# Phase-Adjustable Clock Divider Channel

This block is one output channel of a clock distribution tree. It divides a fast source clock by an integer ratio and gives the divided clock a coarse delay measured in half periods of the source clock. Every edge it produces lands on a rising or a falling edge of the source clock, so no delay setting adds jitter. An invert control flips the output polarity. Odd ratios are corrected to an exact 50% high time by ending the high phase on a falling source edge.

Ratio, delay code and polarity are taken in only while the channel is held. The channel is held while reset or the active-low sync input is low. It starts counting on the first source rising edge at which neither is asserted. Several channels that share the source clock, reset and sync line therefore restart together and keep their edges in a fixed relation. A one-cycle done pulse marks that the first output edge after a restart has been produced.

Top module: `clk_phase_div`

## Requirements
- R1: While `rst_n` or `sync_n` is sampled low, `clk_out` stays at its inactive level, which equals the captured invert bit. `sync_done` stays 0 during that time.
- R2: `ratio_in` holds the divide ratio N as an unsigned value. A value of 0 acts as 1, and values above 32 act as 32. The running output repeats every 2·N half periods of `clk`.
- R3: In each output period the active level lasts exactly N half periods of `clk`, for both even and odd N.
- R4: Let E0 be the first `clk` rising edge at which `rst_n` and `sync_n` are both sampled high. The first active edge of `clk_out` then comes `phase_in` half periods after E0, for codes 0 to 63.
- R5: Ratio, phase code and invert bit are captured only while the channel is held. Changes to them while the channel runs leave the output unchanged.
- R6: With `invert_in` = 1 the output is the exact complement of the non-inverted waveform, including its idle level.
- R7: With N = 1 the output follows `clk` itself. An odd phase code gives `clk` shifted by half a period, and the invert bit still applies.
- R8: `sync_done` is high for exactly one `clk` cycle. It rises on the rising edge at E0 + floor(`phase_in`/2) + 1 cycles, the first rising edge after the first active output edge.
- R9: Releasing `rst_n` with `sync_n` high starts the channel exactly as a sync release does, with no pulse on `sync_n` needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous reset, active low; also holds the channel |
| sync_n | input | 1 | Restart request, active low; the channel stays held while low |
| ratio_in | input | 6 | Divide ratio N (0 acts as 1, above 32 acts as 32) |
| phase_in | input | 6 | Delay in half periods of `clk` |
| invert_in | input | 1 | Output polarity flip |
| clk_out | output | 1 | Divided, delayed clock |
| sync_done | output | 1 | One-cycle pulse after the first active edge following a restart |

## Verification
The inline properties check the following on every cycle: the idle level and the quiet done flag during a hold, that the done pulse lasts one cycle and appears only while running, that the configuration stays frozen while running, that the counter stays in range, and that the odd-ratio tail flag never overlaps the high flag. Half-period timing is a different matter. Exact period, high time, first-edge delay and half-cycle retiming come from edges on both clock phases, so only the bench's scenarios show them. The bench samples the output once per half period and matches each transition to a queued expected slot, across a spread of ratios, codes, polarities and clamped ratio values.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam int unsigned MAX_RATIO = 32;
    localparam int unsigned PHASE_W   = 6;
    localparam int unsigned RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
    localparam int unsigned WAIT_W    = PHASE_W - 1;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               shift;
        logic               inv;
    } div_cfg_t;

    typedef struct packed {
        logic hi;
        logic mark;
        logic tail;
    } edge_flags_t;

    typedef enum logic [1:0] {ST_HOLD, ST_WAIT, ST_RUN} sync_state_e;
    typedef enum logic [1:0] {MODE_PASS, MODE_EVEN, MODE_ODD} shape_mode_e;

    function automatic logic [RATIO_W-1:0] fit_ratio(input logic [RATIO_W-1:0] r);
        if (r == '0) return RATIO_W'(1);
        if (r > RATIO_W'(MAX_RATIO)) return RATIO_W'(MAX_RATIO);
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] high_cycles(input logic [RATIO_W-1:0] n);
        logic [RATIO_W:0] t;
        t = {1'b0, n} + 1'b1;
        return CNT_W'(t >> 1);
    endfunction

    function automatic shape_mode_e shape_mode(input logic [RATIO_W-1:0] n);
        if (n == RATIO_W'(1)) return MODE_PASS;
        if (n[0]) return MODE_ODD;
        return MODE_EVEN;
    endfunction
endpackage

// File: rtl/div_sync_ctrl.sv
`timescale 1ns/1ps
module div_sync_ctrl
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_n,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               invert_in,
    output div_cfg_t           cfg,
    output logic               held,
    output logic               run,
    output logic               start,
    output logic               sync_done
);
    sync_state_e       state_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic              seen_q;
    logic              held_q;

    assign held  = rst | ~sync_n;
    assign run   = (state_q == ST_RUN);
    assign start = ~held & (state_q != ST_RUN) & (wcnt_q == '0);

    always_ff @(posedge clk) begin
        held_q <= held;
        if (held) begin
            state_q   <= ST_HOLD;
            wcnt_q    <= phase_in[PHASE_W-1:1];
            cfg       <= '{ratio: fit_ratio(ratio_in), shift: phase_in[0], inv: invert_in};
            seen_q    <= 1'b0;
            sync_done <= 1'b0;
        end else begin
            if (start) begin
                state_q <= ST_RUN;
            end else if (state_q != ST_RUN) begin
                state_q <= ST_WAIT;
                wcnt_q  <= wcnt_q - 1'b1;
            end
            sync_done <= run & ~seen_q;
            seen_q    <= seen_q | run;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) sync_done |=> !sync_done); // R8
    AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) sync_done |-> run); // R8
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) (!held && !held_q) |-> $stable(cfg)); // R5
endmodule

// File: rtl/div_phase_counter.sv
`timescale 1ns/1ps
module div_phase_counter
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        start,
    input  logic        run,
    input  div_cfg_t    cfg,
    output edge_flags_t flags
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] nxt;

    assign last = CNT_W'(cfg.ratio - 1'b1);
    assign half = high_cycles(cfg.ratio);

    always_comb begin
        if (start || cnt_q == last) nxt = '0;
        else                        nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
            flags <= '0;
        end else if (start || run) begin
            cnt_q      <= nxt;
            flags.hi   <= (nxt < half);
            flags.mark <= (nxt == half - 1'b1);
            flags.tail <= (nxt == half);
        end else begin
            flags <= '0;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) run |-> ({1'b0, cnt_q} < cfg.ratio)); // R2
endmodule

// File: rtl/div_edge_shaper.sv
`timescale 1ns/1ps
module div_edge_shaper
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  div_cfg_t    cfg,
    input  edge_flags_t flags,
    output logic        clk_out
);
    logic        hi_n;
    logic        mark_n;
    logic        early;
    logic        late;
    logic        shaped;
    shape_mode_e mode;

    always_ff @(negedge clk) begin
        if (rst) begin
            hi_n   <= 1'b0;
            mark_n <= 1'b0;
        end else begin
            hi_n   <= flags.hi;
            mark_n <= flags.mark;
        end
    end

    assign mode = shape_mode(cfg.ratio);

    always_comb begin
        case (mode)
            MODE_PASS: begin
                early = clk;
                late  = ~clk;
            end
            MODE_ODD: begin
                early = flags.hi & ~mark_n;
                late  = hi_n & ~flags.tail;
            end
            default: begin
                early = flags.hi;
                late  = hi_n;
            end
        endcase
        shaped  = cfg.shift ? late : early;
        clk_out = cfg.inv ^ (run & shaped);
    end

    AST_ODD_TAIL: assert property (@(posedge clk) disable iff (rst) (run && mode == MODE_ODD && flags.tail) |-> !flags.hi); // R3
endmodule

// File: rtl/clk_phase_div.sv
`timescale 1ns/1ps
module clk_phase_div
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               invert_in,
    output logic               clk_out,
    output logic               sync_done
);
    logic        rst;
    logic        held;
    logic        run;
    logic        start;
    div_cfg_t    cfg;
    edge_flags_t flags;

    assign rst = ~rst_n;

    div_sync_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sync_n(sync_n), .ratio_in(ratio_in), .phase_in(phase_in),
        .invert_in(invert_in), .cfg(cfg), .held(held), .run(run), .start(start),
        .sync_done(sync_done)
    );

    div_phase_counter u_cnt (
        .clk(clk), .rst(rst), .clear(held), .start(start), .run(run), .cfg(cfg), .flags(flags)
    );

    div_edge_shaper u_shape (
        .clk(clk), .rst(rst), .run(run), .cfg(cfg), .flags(flags), .clk_out(clk_out)
    );

    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (rst) (!sync_n) |=> (clk_out == cfg.inv)); // R1
    AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (rst) (!sync_n) |=> !sync_done); // R1
endmodule

// File: tb/tb_clk_phase_div.sv
`timescale 1ns/1ps
module tb_clk_phase_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic [5:0] ratio_in = 6'd4;
    logic [5:0] phase_in = 6'd0;
    logic       invert_in = 1'b0;
    logic       clk_out;
    logic       sync_done;

    clk_phase_div dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .ratio_in(ratio_in), .phase_in(phase_in),
        .invert_in(invert_in), .clk_out(clk_out), .sync_done(sync_done)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    slot;
        logic  lvl;
        string tag;
        string ltag;
    } exp_edge_t;

    exp_edge_t eq[$];
    int        dq[$];
    int        pe = 0;
    int        checks = 0;
    int        fails = 0;
    bit        mon_on = 0;
    bit        finished = 0;
    logic      prev = 1'b0;

    always @(posedge clk) pe <= pe + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sample(input int slot, input bit even);
        logic v;
        v = clk_out;
        if (mon_on && v !== prev) begin
            if (eq.size() == 0) begin
                check(0, "R2", "unexpected output edge at slot", slot, -1);
            end else begin
                exp_edge_t e;
                e = eq.pop_front();
                check(slot == e.slot, e.tag, "edge slot", slot, e.slot);
                check(v === e.lvl, e.ltag, "edge level", int'(v), int'(e.lvl));
            end
            if (eq.size() == 0) mon_on = 0;
        end
        prev = v;
        if (even && sync_done === 1'b1) begin
            if (dq.size() == 0) begin
                check(0, "R8", "unexpected sync_done at edge", pe - 1, -1);
            end else begin
                int d;
                d = dq.pop_front();
                check(pe - 1 == d, "R8", "sync_done edge index", pe - 1, d);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2.5;
            sample(2 * (pe - 1), 1'b1);
            @(negedge clk);
            #2.5;
            sample(2 * (pe - 1) + 1, 1'b0);
        end
    end

    task automatic run_cfg(input int n_raw, input int code, input bit inv, input bit by_reset, input bit disturb);
        int n;
        int e0;
        int r;
        ratio_in  = 6'(n_raw);
        phase_in  = 6'(code);
        invert_in = inv;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check(clk_out === inv, "R1", "held output level", int'(clk_out), int'(inv));
        check(sync_done === 1'b0, "R1", "sync_done while held", int'(sync_done), 0);
        n  = (n_raw == 0) ? 1 : ((n_raw > 32) ? 32 : n_raw);
        e0 = pe;
        r  = 2 * e0 + code;
        for (int k = 0; k < 6; k++) begin
            exp_edge_t e;
            string     tg;
            if (disturb)          tg = "R5";
            else if (k == 0)      tg = by_reset ? "R9" : "R4";
            else if (n == 1)      tg = "R7";
            else if (k % 2 == 1)  tg = "R3";
            else                  tg = "R2";
            e.slot = r + k * n;
            e.lvl  = (k % 2 == 0) ? ~inv : inv;
            e.tag  = tg;
            e.ltag = inv ? "R6" : tg;
            eq.push_back(e);
        end
        dq.push_back(e0 + code / 2 + 1);
        mon_on = 1;
        if (by_reset) rst_n = 1'b1;
        else          sync_n = 1'b1;
        if (disturb) begin
            repeat (3) @(negedge clk);
            ratio_in  = ratio_in ^ 6'h05;
            phase_in  = ~phase_in;
            invert_in = ~inv;
        end
        while (eq.size() != 0 || dq.size() != 0) @(posedge clk);
        @(negedge clk);
        #1;
        sync_n = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        run_cfg(4, 0, 1'b0, 1'b1, 1'b0);
        run_cfg(1, 0, 1'b0, 1'b0, 1'b0);
        run_cfg(1, 1, 1'b1, 1'b0, 1'b0);
        run_cfg(2, 63, 1'b0, 1'b0, 1'b0);
        run_cfg(3, 5, 1'b0, 1'b0, 1'b0);
        run_cfg(5, 2, 1'b1, 1'b0, 1'b0);
        run_cfg(7, 0, 1'b1, 1'b0, 1'b1);
        run_cfg(6, 1, 1'b0, 1'b0, 1'b0);
        run_cfg(32, 7, 1'b0, 1'b0, 1'b0);
        run_cfg(32, 62, 1'b1, 1'b0, 1'b0);
        run_cfg(0, 3, 1'b0, 1'b0, 1'b0);
        run_cfg(45, 4, 1'b1, 1'b0, 1'b0);
        run_cfg(9, 33, 1'b0, 1'b0, 1'b1);
        run_cfg(3, 0, 1'b1, 1'b0, 1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (!finished && pe > 100000) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired: actual %0d cycles expected completion", pe);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule